// File: doc/BRIEF.md
# Tournament Local/Global Branch Direction Predictor

This block guesses the direction of conditional branches. It combines two component predictors. The first works per branch: a history table, indexed by a hash of the fetch address, records the recent outcomes of that branch, and that history then selects a saturating counter in a shared table. The second works on the whole program path: a global outcome shift register selects a saturating counter in its own table. A third table, also indexed by the global history, holds chooser counters. Each chooser counter decides which of the two component guesses becomes the final prediction.

A lookup is purely combinational. The fetch stage drives a fetch address and reads the final prediction at once, together with both component predictions, which it keeps until the branch resolves. At resolve time the pipeline returns the branch address, the real outcome and the two stored component predictions. All tables then train in one clock edge. A synchronous context-clear input returns every table and history to its initial state, and the asynchronous reset does the same.

Top module: `tournament_bp`

## Requirements
- R1: The local history entry is selected by the XOR of all LHT_IDX_W-bit slices of the fetch address, with the slices taken from bit 0 upward and the top slice zero-padded.
- R2: The selected local history, LHIST_W bits wide, indexes the shared table of LCNT_W-bit local counters. The local prediction is the MSB of that counter (1 = taken).
- R3: On a resolve, the local history entry of the resolved address shifts left and takes the outcome (1 = taken) into bit 0. The local counter that the old history selected steps one toward the outcome.
- R4: The global prediction is the MSB of the GCNT_W-bit counter selected by the global history. On a resolve, that counter steps one toward the outcome.
- R5: The global history register shifts left on each resolve and takes the outcome into bit 0. It does not change in cycles without a resolve.
- R6: The final prediction is the global prediction when the MSB of the chooser counter selected by the global history is 1. Otherwise it is the local prediction.
- R7: The chooser counter changes only when the returned local and global predictions differ. It steps up when the global one matched the outcome and down when the local one matched.
- R8: Every counter saturates at zero and at its all-ones value.
- R9: After reset or a context clear, LCNT_W-bit counters hold 2^(LCNT_W-1)-1 (011 for three bits), two-bit counters hold 01, and all histories hold zero. Every prediction is therefore not-taken. A clear takes precedence over a resolve in the same cycle.
- R10: A lookup reflects the table state before any resolve in the same cycle takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_clear | input | 1 | Synchronous clear of all tables and histories |
| lk_addr | input | ADDR_W | Fetch address for the lookup |
| pred_taken | output | 1 | Final direction prediction |
| pred_local | output | 1 | Local component prediction |
| pred_global | output | 1 | Global component prediction |
| rs_valid | input | 1 | A conditional branch resolves this cycle |
| rs_addr | input | ADDR_W | Address of the resolving branch |
| rs_taken | input | 1 | Real outcome (1 = taken) |
| rs_local_pred | input | 1 | Local prediction captured at lookup |
| rs_global_pred | input | 1 | Global prediction captured at lookup |

## Verification
The main flow is tried with a loop-closing branch (taken three times, then not taken), a strictly alternating branch and an always-taken branch. The three are interleaved so that the local history patterns and the global path pull the chooser in opposite directions. The loop branch separates per-branch history from path history. The alternating branch only becomes predictable through history bits. Long runs of one outcome drive every counter into saturation at both ends. Resolves with forced agreeing predictions check that the chooser is not trained. A clear that coincides with a resolve, and idle cycles with stray resolve fields, check that state changes only when it should.

// File: rtl/tp_pkg.sv
package tp_pkg;

    // Saturating step of a counter of up to 8 bits; top is the all-ones value.
    function automatic logic [7:0] sat_move(input logic [7:0] cur,
                                            input logic [7:0] top,
                                            input logic       up);
        if (up) begin
            return (cur >= top) ? cur : cur + 8'd1;
        end
        return (cur == 8'd0) ? cur : cur - 8'd1;
    endfunction

endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
    parameter int IDX_W = 12,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             up_en,
    input  logic [IDX_W-1:0] up_idx,
    input  logic             up_inc
);
    import tp_pkg::*;

    localparam int N = 1 << IDX_W;
    localparam logic [CNT_W-1:0] INIT = CNT_W'((1 << (CNT_W - 1)) - 1);
    localparam logic [CNT_W-1:0] MAX  = '1;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] val;
    } wr_t;

    logic [CNT_W-1:0] tab_q [N];
    wr_t              wr_d;

    assign rd_msb = tab_q[rd_idx][CNT_W-1];

    always_comb begin
        wr_d.en  = up_en;
        wr_d.idx = up_idx;
        wr_d.val = CNT_W'(sat_move(8'(tab_q[up_idx]), 8'(MAX), up_inc));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tab_q[i] <= INIT;
        end else if (clr) begin
            for (int i = 0; i < N; i++) tab_q[i] <= INIT;
        end else if (wr_d.en) begin
            tab_q[wr_d.idx] <= wr_d.val;
        end
    end

endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              up_en,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic              up_bit,
    output logic [HIST_W-1:0] up_hist
);
    localparam int N = 1 << IDX_W;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [HIST_W-1:0] val;
    } wr_t;

    logic [HIST_W-1:0] tab_q [N];
    wr_t               wr_d;

    assign rd_hist = tab_q[rd_idx];
    assign up_hist = tab_q[up_idx];

    always_comb begin
        wr_d.en  = up_en;
        wr_d.idx = up_idx;
        wr_d.val = {up_hist[HIST_W-2:0], up_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) tab_q[i] <= '0;
        end else if (clr) begin
            for (int i = 0; i < N; i++) tab_q[i] <= '0;
        end else if (wr_d.en) begin
            tab_q[wr_d.idx] <= wr_d.val;
        end
    end

endmodule

// File: rtl/tournament_bp.sv
module tournament_bp #(
    parameter int ADDR_W    = 32,
    parameter int LHT_IDX_W = 10,
    parameter int LHIST_W   = 10,
    parameter int LCNT_W    = 3,
    parameter int GHIST_W   = 12,
    parameter int GCNT_W    = 2,
    parameter int CCNT_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctx_clear,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              pred_taken,
    output logic              pred_local,
    output logic              pred_global,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_addr,
    input  logic              rs_taken,
    input  logic              rs_local_pred,
    input  logic              rs_global_pred
);
    localparam int N_SLICE = (ADDR_W + LHT_IDX_W - 1) / LHT_IDX_W;
    localparam int PAD_W   = N_SLICE * LHT_IDX_W;

    typedef struct packed {
        logic [GHIST_W-1:0] ghr;
    } state_t;

    state_t st_d, st_q;

    logic [LHT_IDX_W-1:0] lk_idx, rs_idx;
    logic [LHIST_W-1:0]   lk_hist, rs_hist;
    logic                 choose_global;
    logic                 rs_upd, cho_upd;

    function automatic logic [LHT_IDX_W-1:0] fold_addr(input logic [ADDR_W-1:0] a);
        logic [PAD_W-1:0]     p;
        logic [LHT_IDX_W-1:0] acc;
        p   = PAD_W'(a);
        acc = '0;
        for (int i = 0; i < N_SLICE; i++) acc ^= p[i*LHT_IDX_W +: LHT_IDX_W];
        return acc;
    endfunction

    assign lk_idx  = fold_addr(lk_addr);
    assign rs_idx  = fold_addr(rs_addr);
    assign rs_upd  = rs_valid && !ctx_clear;
    assign cho_upd = rs_upd && (rs_local_pred != rs_global_pred);

    tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (ctx_clear),
        .rd_idx  (lk_idx),
        .rd_hist (lk_hist),
        .up_en   (rs_upd),
        .up_idx  (rs_idx),
        .up_bit  (rs_taken),
        .up_hist (rs_hist)
    );

    tp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_lct (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctx_clear),
        .rd_idx (lk_hist),
        .rd_msb (pred_local),
        .up_en  (rs_upd),
        .up_idx (rs_hist),
        .up_inc (rs_taken)
    );

    tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W)) u_gct (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctx_clear),
        .rd_idx (st_q.ghr),
        .rd_msb (pred_global),
        .up_en  (rs_upd),
        .up_idx (st_q.ghr),
        .up_inc (rs_taken)
    );

    tp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(CCNT_W)) u_cht (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (ctx_clear),
        .rd_idx (st_q.ghr),
        .rd_msb (choose_global),
        .up_en  (cho_upd),
        .up_idx (st_q.ghr),
        .up_inc (rs_global_pred == rs_taken)
    );

    assign pred_taken = choose_global ? pred_global : pred_local;

    always_comb begin
        st_d = st_q;
        if (ctx_clear) begin
            st_d.ghr = '0;
        end else if (rs_valid) begin
            st_d.ghr = {st_q.ghr[GHIST_W-2:0], rs_taken};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tournament_bp_check.sv
module tournament_bp_check #(
    parameter int GHIST_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ctx_clear,
    input logic               rs_valid,
    input logic               rs_taken,
    input logic [GHIST_W-1:0] ghr,
    input logic               pred_taken,
    input logic               pred_local,
    input logic               pred_global
);
    a_r5_ghr_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !ctx_clear) |=>
            (ghr[0] == $past(rs_taken)) && (ghr[GHIST_W-1:1] == $past(ghr[GHIST_W-2:0])));

    a_r5_ghr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rs_valid && !ctx_clear) |=> $stable(ghr));

    a_r9_clear_hist: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> (ghr == '0));

    a_r9_clear_pred: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_clear |=> (!pred_local && !pred_global && !pred_taken));

    a_r6_agree_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_global) |-> (pred_taken == pred_local));

endmodule

bind tournament_bp tournament_bp_check #(.GHIST_W(GHIST_W)) u_check (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctx_clear   (ctx_clear),
    .rs_valid    (rs_valid),
    .rs_taken    (rs_taken),
    .ghr         (st_q.ghr),
    .pred_taken  (pred_taken),
    .pred_local  (pred_local),
    .pred_global (pred_global)
);

// File: tb/tournament_bp_bench.sv
module tournament_bp_bench;
    localparam int AW = 8;
    localparam int LI = 2;
    localparam int LH = 3;
    localparam int GH = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctx_clear = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic          pred_taken, pred_local, pred_global;
    logic          rs_valid = 1'b0;
    logic [AW-1:0] rs_addr = '0;
    logic          rs_taken = 1'b0;
    logic          rs_local_pred = 1'b0;
    logic          rs_global_pred = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    tournament_bp #(
        .ADDR_W(AW), .LHT_IDX_W(LI), .LHIST_W(LH), .LCNT_W(3),
        .GHIST_W(GH), .GCNT_W(2), .CCNT_W(2)
    ) u_tournament_bp (
        .clk(clk), .rst_n(rst_n), .ctx_clear(ctx_clear), .lk_addr(lk_addr),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_global(pred_global),
        .rs_valid(rs_valid), .rs_addr(rs_addr), .rs_taken(rs_taken),
        .rs_local_pred(rs_local_pred), .rs_global_pred(rs_global_pred)
    );

    // Reference state built from the requirements
    logic [LH-1:0] m_lht [1<<LI];
    logic [2:0]    m_lct [1<<LH];
    logic [1:0]    m_gct [1<<GH];
    logic [1:0]    m_cht [1<<GH];
    logic [GH-1:0] m_ghr;

    // Stimulus vectors: {address, outcome}
    localparam logic [AW:0] VEC [24] = '{
        {8'h11,1'b1}, {8'h22,1'b1}, {8'h07,1'b1}, {8'h11,1'b1},
        {8'h22,1'b0}, {8'h11,1'b1}, {8'h07,1'b1}, {8'h11,1'b0},
        {8'h22,1'b1}, {8'h11,1'b1}, {8'h22,1'b0}, {8'h11,1'b1},
        {8'h07,1'b1}, {8'h11,1'b1}, {8'h11,1'b0}, {8'h22,1'b1},
        {8'h11,1'b1}, {8'h22,1'b0}, {8'h11,1'b1}, {8'h07,1'b1},
        {8'h11,1'b1}, {8'h11,1'b0}, {8'h22,1'b1}, {8'h07,1'b1}
    };

    function automatic logic [LI-1:0] m_fold(input logic [AW-1:0] a);
        logic [LI-1:0] acc = '0;
        for (int i = 0; i < AW / LI; i++) acc ^= a[i*LI +: LI];
        return acc;
    endfunction

    function automatic logic m_local(input logic [AW-1:0] a);
        return m_lct[m_lht[m_fold(a)]][2];
    endfunction

    function automatic logic m_global();
        return m_gct[m_ghr][1];
    endfunction

    function automatic logic m_final(input logic [AW-1:0] a);
        return m_cht[m_ghr][1] ? m_global() : m_local(a);
    endfunction

    task automatic m_clear();
        for (int i = 0; i < (1<<LI); i++) m_lht[i] = '0;
        for (int i = 0; i < (1<<LH); i++) m_lct[i] = 3'b011;
        for (int i = 0; i < (1<<GH); i++) begin
            m_gct[i] = 2'b01;
            m_cht[i] = 2'b01;
        end
        m_ghr = '0;
    endtask

    task automatic m_resolve(input logic [AW-1:0] a, input logic t,
                             input logic lp, input logic gp);
        logic [LI-1:0] li;
        logic [LH-1:0] h;
        li = m_fold(a);
        h  = m_lht[li];
        if (t) m_lct[h] = (m_lct[h] == 3'd7) ? 3'd7 : m_lct[h] + 3'd1;
        else   m_lct[h] = (m_lct[h] == 3'd0) ? 3'd0 : m_lct[h] - 3'd1;
        m_lht[li] = {h[LH-2:0], t};
        if (t) m_gct[m_ghr] = (m_gct[m_ghr] == 2'd3) ? 2'd3 : m_gct[m_ghr] + 2'd1;
        else   m_gct[m_ghr] = (m_gct[m_ghr] == 2'd0) ? 2'd0 : m_gct[m_ghr] - 2'd1;
        if (lp != gp) begin
            if (gp == t) m_cht[m_ghr] = (m_cht[m_ghr] == 2'd3) ? 2'd3 : m_cht[m_ghr] + 2'd1;
            else         m_cht[m_ghr] = (m_cht[m_ghr] == 2'd0) ? 2'd0 : m_cht[m_ghr] - 2'd1;
        end
        m_ghr = {m_ghr[GH-2:0], t};
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Look up at addr, check all three outputs, then resolve the same branch.
    // force_agree returns the local guess in place of the global one (R7).
    task automatic step(input logic [AW-1:0] a, input logic t,
                        input bit force_agree, input string req);
        logic lp, gp;
        @(negedge clk);
        lk_addr = a;
        #1;
        chk({req, " local"},  pred_local,  m_local(a));
        chk({req, " global"}, pred_global, m_global());
        chk({req, " final"},  pred_taken,  m_final(a));
        lp = pred_local;
        gp = force_agree ? pred_local : pred_global;
        rs_valid = 1'b1; rs_addr = a; rs_taken = t;
        rs_local_pred = lp; rs_global_pred = gp;
        @(posedge clk);
        m_resolve(a, t, lp, gp);
        #1;
        rs_valid = 1'b0;
    endtask

    task automatic probe(input logic [AW-1:0] a, input string req);
        @(negedge clk);
        lk_addr = a;
        #1;
        chk({req, " local"},  pred_local,  m_local(a));
        chk({req, " global"}, pred_global, m_global());
        chk({req, " final"},  pred_taken,  m_final(a));
    endtask

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state predicts not-taken everywhere
        probe(8'h00, "R9 reset");
        probe(8'hA5, "R9 reset");
        chk("R9 reset final", pred_taken, 1'b0);

        // R1 R2 R3 R4 R5 R6 R7 R10: vector walk over mixed branch patterns
        foreach (VEC[i]) step(VEC[i][AW:1], VEC[i][0], 1'b0, "R2 R4 R6 vector");

        // R8: saturation by long runs in both directions
        for (int i = 0; i < 10; i++) step(8'h30, 1'b1, 1'b0, "R8 sat high");
        for (int i = 0; i < 10; i++) step(8'h30, 1'b0, 1'b0, "R8 sat low");
        for (int i = 0; i < 10; i++) step(8'h30, 1'b1, 1'b0, "R8 sat back");

        // R7: agreeing returned predictions leave the chooser alone
        for (int i = 0; i < 8; i++) step(8'h5C, i[0], 1'b1, "R7 agree");
        for (int i = 0; i < 8; i++) step(8'h5C, i[1], 1'b0, "R7 train");

        // R1: addresses that fold to the same index share one history
        step(8'h01, 1'b1, 1'b0, "R1 alias");
        step(8'h04, 1'b1, 1'b0, "R1 alias");
        step(8'h10, 1'b1, 1'b0, "R1 alias");
        probe(8'h40, "R1 alias");

        // R5: stray resolve fields without rs_valid change nothing
        @(negedge clk);
        rs_addr = 8'h11; rs_taken = 1'b0; rs_local_pred = 1'b1; rs_global_pred = 1'b0;
        repeat (4) @(negedge clk);
        probe(8'h11, "R5 idle");
        probe(8'h30, "R5 idle");

        // R9: clear coinciding with a resolve wins
        @(negedge clk);
        ctx_clear = 1'b1; rs_valid = 1'b1; rs_addr = 8'h30; rs_taken = 1'b1;
        @(posedge clk);
        m_clear();
        #1;
        ctx_clear = 1'b0; rs_valid = 1'b0;
        probe(8'h30, "R9 clear");
        probe(8'h11, "R9 clear");
        chk("R9 clear final", pred_taken, 1'b0);

        // R3 R10: retrain after clear
        for (int i = 0; i < 6; i++) step(8'h22, i[0], 1'b0, "R3 R10 retrain");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule